// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by fetching descriptors from a translation table kept in memory. The first-level table starts at an address held in a base register that software loads through a one-cycle write strobe. The walker reads one first-level word. That word either maps a 1MB section directly, points to a second-level table, or marks the address as unmapped. When it points to a second-level table, the walker reads one more word. That word maps a 64KB, 4KB or 1KB page, or faults.

Only one translation is in progress at a time. The requester offers an address with a valid/ready handshake. The walker issues its word reads over a request/response port: the request holds until it is accepted, and exactly one response word comes back for each accepted request. Completion is a single-cycle `done` pulse. It carries either a fault flag, with the level that faulted, or the physical address, the 4-bit domain number and the 2-bit access-permission code that applies to the addressed part of the mapping. Checking those permissions is left to the consumer.

Top module: `xw_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `mem_rd_valid` are 0.
- R2: The first read address is {base[31:14], va[31:20], 2'b00}. `base` is the value the base register held when the request was accepted, so a base write in the same cycle as acceptance takes effect from the next request.
- R3: A first-level word with bits[1:0]=10 ends the walk after one read: pa = {d[31:20], va[19:0]}, ap = d[11:10], domain = d[8:5], fault = 0.
- R4: A first-level word with bits[1:0]=00 ends the walk after one read with fault=1 and fault_lvl2=0. On any fault, pa, domain and ap are 0.
- R5: First-level bits[1:0]=01 selects a coarse table, read at {d[31:10], va[19:12], 2'b00}. Bits[1:0]=11 selects a fine table, read at {d[31:12], va[19:10], 2'b00}. The domain of the result comes from d[8:5] of the first-level word.
- R6: A second-level word with bits[1:0]=01 maps a large page: pa = {s[31:16], va[15:0]}. ap is the 2-bit field of s[11:4] picked by va[15:14], where 0 selects s[5:4], 1 selects s[7:6], 2 selects s[9:8] and 3 selects s[11:10].
- R7: A second-level word with bits[1:0]=10 maps a small page: pa = {s[31:12], va[11:0]}. ap is picked from s[11:4] by va[11:10], using the same encoding as R6.
- R8: A second-level word with bits[1:0]=11 inside a fine table maps a tiny page: pa = {s[31:10], va[9:0]} and ap = s[5:4]. The same type inside a coarse table, or type 00 in any table, gives fault=1 with fault_lvl2=1.
- R9: `done` is high for exactly one cycle, in the cycle after the last response word. `req_ready` is low from acceptance until that cycle. A new request can be accepted in the `done` cycle.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base value |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_va | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Word read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| fault_lvl2 | output | 1 | Fault came from the second-level word |
| pa | output | 32 | Physical address |
| domain | output | 4 | Domain number of the mapping |
| ap | output | 2 | Access-permission code for the addressed sub-region |

## Verification
Two things can coincide with the end of a walk. One is the acceptance of the next request, which can happen in the same cycle as the completion pulse. The other is a write to the base register in the same cycle a request is accepted. The bench provokes the first by raising a new request at the moment `done` is seen. It then checks that the pulse lasts one cycle, that both results are correct and that the second walk reads the right addresses. It provokes the second by raising `base_we` and `req_valid` together and checking that the first read still uses the old base while the following walk uses the new one.

// File: rtl/xw_pkg.sv
// Shared constants, encodings and result type for the translation walker.
// Assumes a 32-bit virtual and physical address and word-sized descriptors.
package xw_pkg;
    localparam int VA_W       = 32;
    localparam int DOM_W      = 4;
    localparam int AP_W       = 2;
    localparam int BASE_LSB   = 14;   // table base alignment (16KB)
    localparam int SEC_LSB    = 20;   // section size 1MB
    localparam int LARGE_LSB  = 16;   // large page 64KB
    localparam int SMALL_LSB  = 12;   // small page 4KB
    localparam int TINY_LSB   = 10;   // tiny page 1KB
    localparam int CTBL_LSB   = 10;   // coarse table alignment
    localparam int FTBL_LSB   = 12;   // fine table alignment
    localparam int DOM_LSB    = 5;
    localparam int SAP_LSB    = 10;   // section permission field
    localparam int SUBAP_LSB  = 4;    // first sub-region permission field

    typedef enum logic [1:0] {
        L1_FAULT   = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'b00,
        L2_LARGE = 2'b01,
        L2_SMALL = 2'b10,
        L2_TINY  = 2'b11
    } l2_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT
    } walk_st_e;

    typedef struct packed {
        logic             fault;
        logic             lvl2;
        logic [VA_W-1:0]  pa;
        logic [DOM_W-1:0] dom;
        logic [AP_W-1:0]  ap;
    } walk_res_t;
endpackage

// File: rtl/xw_l1_decode.sv
// First-level descriptor decoder: classifies the word and forms the section
// result and the second-level table word address. Purely combinational.
// Assumes the descriptor is presented on the memory response data.
module xw_l1_decode
    import xw_pkg::*;
(
    input  logic [VA_W-1:0]  desc,
    input  logic [VA_W-1:0]  va,
    output l1_kind_e         kind,
    output logic [VA_W-1:0]  sec_pa,
    output logic [AP_W-1:0]  sec_ap,
    output logic [DOM_W-1:0] dom,
    output logic [VA_W-1:0]  l2_addr
);
    logic [VA_W-1:0] coarse_addr;
    logic [VA_W-1:0] fine_addr;
    logic            unused_bits;

    // Classify the descriptor and extract its common fields.
    always_comb begin
        kind        = l1_kind_e'(desc[1:0]);
        sec_pa      = {desc[VA_W-1:SEC_LSB], va[SEC_LSB-1:0]};
        sec_ap      = desc[SAP_LSB +: AP_W];
        dom         = desc[DOM_LSB +: DOM_W];
        coarse_addr = {desc[VA_W-1:CTBL_LSB], va[SEC_LSB-1:SMALL_LSB], 2'b00};
        fine_addr   = {desc[VA_W-1:FTBL_LSB], va[SEC_LSB-1:TINY_LSB], 2'b00};
        l2_addr     = (kind == L1_FINE) ? fine_addr : coarse_addr;
    end

    assign unused_bits = ^{desc[9], desc[4:2]};
endmodule

// File: rtl/xw_l2_decode.sv
// Second-level descriptor decoder: resolves large, small and tiny pages,
// selects the sub-region permission code and flags illegal words.
// Assumes `in_fine` tells whether the word came from a fine table.
module xw_l2_decode
    import xw_pkg::*;
(
    input  logic [VA_W-1:0] desc,
    input  logic [VA_W-1:0] va,
    input  logic            in_fine,
    output logic            fault,
    output logic [VA_W-1:0] pg_pa,
    output logic [AP_W-1:0] pg_ap
);
    localparam int N_SUB = 4;

    logic [AP_W-1:0] sub_ap [N_SUB];
    logic            unused_bits;

    // Split the sub-region permission byte into its four fields.
    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
        assign sub_ap[g] = desc[SUBAP_LSB + AP_W*g +: AP_W];
    end

    // Map the page type to address, permission and fault.
    always_comb begin
        fault = 1'b0;
        pg_pa = '0;
        pg_ap = '0;
        unique case (l2_kind_e'(desc[1:0]))
            L2_LARGE: begin
                pg_pa = {desc[VA_W-1:LARGE_LSB], va[LARGE_LSB-1:0]};
                pg_ap = sub_ap[va[LARGE_LSB-1:LARGE_LSB-2]];
            end
            L2_SMALL: begin
                pg_pa = {desc[VA_W-1:SMALL_LSB], va[SMALL_LSB-1:0]};
                pg_ap = sub_ap[va[SMALL_LSB-1:SMALL_LSB-2]];
            end
            L2_TINY: begin
                if (in_fine) begin
                    pg_pa = {desc[VA_W-1:TINY_LSB], va[TINY_LSB-1:0]};
                    pg_ap = sub_ap[0];
                end else begin
                    fault = 1'b1;
                end
            end
            default: fault = 1'b1;
        endcase
    end

    assign unused_bits = ^desc[3:2];
endmodule

// File: rtl/xw_walk_fsm.sv
// Walk sequencer: accepts one request, issues the first- and second-level
// reads, and registers the one-cycle result. Assumes exactly one response
// word returns for every accepted read request.
module xw_walk_fsm
    import xw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  tbl_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    output logic [VA_W-1:0]  va_q,
    output logic             fine_q,
    input  l1_kind_e         l1_kind,
    input  logic [VA_W-1:0]  l1_pa,
    input  logic [AP_W-1:0]  l1_ap,
    input  logic [DOM_W-1:0] l1_dom,
    input  logic [VA_W-1:0]  l1_next,
    input  logic             l2_fault,
    input  logic [VA_W-1:0]  l2_pa,
    input  logic [AP_W-1:0]  l2_ap,
    output logic             done,
    output walk_res_t        res
);
    walk_st_e         state_q;
    logic [VA_W-1:0]  addr_q;
    logic [DOM_W-1:0] dom_q;

    // Handshake outputs decoded from the state.
    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign mem_rd_addr  = addr_q;

    // Sequence the walk and register the completion result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            va_q    <= '0;
            fine_q  <= 1'b0;
            dom_q   <= '0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        addr_q  <= {tbl_base[VA_W-1:BASE_LSB], req_va[VA_W-1:SEC_LSB], 2'b00};
                        state_q <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_rd_ready) state_q <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (l1_kind)
                            L1_SECTION: begin
                                done    <= 1'b1;
                                res     <= '{fault: 1'b0, lvl2: 1'b0, pa: l1_pa, dom: l1_dom, ap: l1_ap};
                                state_q <= ST_IDLE;
                            end
                            L1_FAULT: begin
                                done    <= 1'b1;
                                res     <= '{fault: 1'b1, lvl2: 1'b0, pa: '0, dom: '0, ap: '0};
                                state_q <= ST_IDLE;
                            end
                            default: begin
                                addr_q  <= l1_next;
                                fine_q  <= (l1_kind == L1_FINE);
                                dom_q   <= l1_dom;
                                state_q <= ST_L2_REQ;
                            end
                        endcase
                    end
                end
                ST_L2_REQ: begin
                    if (mem_rd_ready) state_q <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        done <= 1'b1;
                        if (l2_fault)
                            res <= '{fault: 1'b1, lvl2: 1'b1, pa: '0, dom: '0, ap: '0};
                        else
                            res <= '{fault: 1'b0, lvl2: 1'b0, pa: l2_pa, dom: dom_q, ap: l2_ap};
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xw_walker.sv
// Top of the two-level translation walker: holds the table base register
// and connects the sequencer to both descriptor decoders.
// Assumes the memory returns responses in request order, one per read.
module xw_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [VA_W-1:0]   base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic              fault_lvl2,
    output logic [VA_W-1:0]   pa,
    output logic [DOM_W-1:0]  domain,
    output logic [AP_W-1:0]   ap
);
    logic [VA_W-1:0]  base_q;
    logic [VA_W-1:0]  va_q;
    logic             fine_q;
    l1_kind_e         l1_kind;
    logic [VA_W-1:0]  l1_pa;
    logic [AP_W-1:0]  l1_ap;
    logic [DOM_W-1:0] l1_dom;
    logic [VA_W-1:0]  l1_next;
    logic             l2_fault;
    logic [VA_W-1:0]  l2_pa;
    logic [AP_W-1:0]  l2_ap;
    walk_res_t        res;

    // Table base register, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    xw_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_base      (base_q),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .va_q          (va_q),
        .fine_q        (fine_q),
        .l1_kind       (l1_kind),
        .l1_pa         (l1_pa),
        .l1_ap         (l1_ap),
        .l1_dom        (l1_dom),
        .l1_next       (l1_next),
        .l2_fault      (l2_fault),
        .l2_pa         (l2_pa),
        .l2_ap         (l2_ap),
        .done          (done),
        .res           (res)
    );

    xw_l1_decode u_l1 (
        .desc    (mem_rsp_data),
        .va      (va_q),
        .kind    (l1_kind),
        .sec_pa  (l1_pa),
        .sec_ap  (l1_ap),
        .dom     (l1_dom),
        .l2_addr (l1_next)
    );

    xw_l2_decode u_l2 (
        .desc    (mem_rsp_data),
        .va      (va_q),
        .in_fine (fine_q),
        .fault   (l2_fault),
        .pg_pa   (l2_pa),
        .pg_ap   (l2_ap)
    );

    // Result fields driven straight from the registered result.
    assign fault      = res.fault;
    assign fault_lvl2 = res.lvl2;
    assign pa         = res.pa;
    assign domain     = res.dom;
    assign ap         = res.ap;
endmodule

// File: rtl/xw_walker_chk.sv
// Protocol and result checker for the walker, attached by bind.
// Observes ports only.
module xw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic        fault,
    input logic [31:0] pa,
    input logic [3:0]  domain,
    input logic [1:0]  ap
);
    assert_one_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid));

    assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid);

    assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> (pa == 32'd0) && (domain == 4'd0) && (ap == 2'd0));
endmodule

bind xw_walker xw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .pa            (pa),
    .domain        (domain),
    .ap            (ap)
);

// File: tb/sim_xw_walker.sv
// Directed bench for the translation walker: a small word memory answers
// reads one cycle after acceptance; each task sets up tables and checks.
module sim_xw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault, fault_lvl2;
    logic [31:0] pa;
    logic [3:0]  domain;
    logic [1:0]  ap;

    logic [31:0] m_addr [MEM_N];
    logic [31:0] m_data [MEM_N];
    int          m_n = 0;
    logic [31:0] rd_log [4];
    int          rd_cnt = 0;
    logic        stall_en = 1'b0;
    logic        tog = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xw_walker u0 (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_lvl2(fault_lvl2),
        .pa(pa), .domain(domain), .ap(ap)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < m_n; i++)
            if (m_addr[i] == a) return m_data[i];
        return 32'h0;
    endfunction

    // Memory model: optional alternating stall, one-cycle response latency.
    assign mem_rd_ready = !stall_en || tog;
    always @(posedge clk) begin
        tog           <= ~tog;
        mem_rsp_valid <= 1'b0;
        if (mem_rd_valid && mem_rd_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= lookup(mem_rd_addr);
            if (rd_cnt < 4) rd_log[rd_cnt] <= mem_rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mem_reset();
        m_n = 0;
    endtask

    task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
        m_addr[m_n] = a;
        m_data[m_n] = d;
        m_n++;
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (done !== 1'b1 && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_res(input string req, input logic ef, input logic el2, input logic [31:0] epa,
                             input logic [3:0] edom, input logic [1:0] eap);
        chk(req, "done", done, 1);
        chk(req, "fault", fault, ef);
        chk(req, "fault_lvl2", fault_lvl2, el2);
        chk(req, "pa", pa, epa);
        chk(req, "domain", domain, edom);
        chk(req, "ap", ap, eap);
    endtask

    // One full walk with result, read-address and latency checks.
    task automatic do_walk(input string req, input logic [31:0] va, input logic ef, input logic el2,
                           input logic [31:0] epa, input logic [3:0] edom, input logic [1:0] eap,
                           input int nreads, input logic [31:0] a1, input logic [31:0] a2, input int elat);
        int lat;
        rd_cnt = 0;
        @(negedge clk); req_valid = 1'b1; req_va = va;
        @(negedge clk); req_valid = 1'b0;
        chk("R9", "req_ready low after accept", req_ready, 0);
        wait_done(lat);
        check_res(req, ef, el2, epa, edom, eap);
        chk("R2", "first read address", rd_log[0], a1);
        chk(req, "read count", rd_cnt, nreads);
        if (nreads == 2) chk("R5", "second read address", rd_log[1], a2);
        if (elat > 0) chk("R9", "done latency", lat, elat);
        @(negedge clk);
        chk("R9", "done one cycle", done, 0);
    endtask

    function automatic logic [31:0] l1a(input logic [31:0] b, input logic [31:0] va);
        return {b[31:14], va[31:20], 2'b00};
    endfunction

    task automatic t_reset();
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "done", done, 0);
        chk("R1", "mem_rd_valid", mem_rd_valid, 0);
    endtask

    task automatic t_section();
        logic [31:0] b = 32'h0012_4000, va = 32'hABC1_2345, d;
        d = {12'h7F1, 8'h00, 2'b11, 1'b0, 4'd5, 3'b000, 2'b10};
        set_base(b); mem_reset(); mem_put(l1a(b, va), d);
        do_walk("R3", va, 0, 0, {12'h7F1, va[19:0]}, 4'd5, 2'b11, 1, l1a(b, va), 0, 2);
    endtask

    task automatic t_l1_fault();
        logic [31:0] b = 32'h0012_4000, va = 32'h5550_0010;
        mem_reset(); mem_put(l1a(b, va), 32'hFFFF_FFE0);
        do_walk("R4", va, 1, 0, 0, 0, 0, 1, l1a(b, va), 0, 2);
    endtask

    task automatic t_coarse_large();
        logic [31:0] b = 32'h0012_4000, va = 32'h1238_9ABC, ta;
        logic [21:0] tb = 22'h0A5C3;
        ta = {tb, va[19:12], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 1'b0, 4'd9, 3'b000, 2'b01});
        mem_put(ta, {16'hBEEF, 4'h0, 8'hE4, 2'b00, 2'b01});
        // va[15:14]=2 selects s[9:8]=10
        do_walk("R6", va, 0, 0, {16'hBEEF, va[15:0]}, 4'd9, 2'b10, 2, l1a(b, va), ta, 4);
    endtask

    task automatic t_coarse_small();
        logic [31:0] b = 32'h0012_4000, va = 32'h0457_0400, ta;
        logic [21:0] tb = 22'h1F00F;
        ta = {tb, va[19:12], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 1'b0, 4'd12, 3'b000, 2'b01});
        mem_put(ta, {20'hCAFE1, 8'hE4, 2'b00, 2'b10});
        // va[11:10]=1 selects s[7:6]=01
        do_walk("R7", va, 0, 0, {20'hCAFE1, va[11:0]}, 4'd12, 2'b01, 2, l1a(b, va), ta, 4);
    endtask

    task automatic t_fine_small();
        logic [31:0] b = 32'h0012_4000, va = 32'h0C0A_BC00, ta;
        logic [19:0] tb = 20'h33221;
        ta = {tb, va[19:10], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 3'b000, 4'd6, 3'b000, 2'b11});
        mem_put(ta, {20'h00ABC, 8'h1B, 2'b00, 2'b10});
        // va[11:10]=3 selects s[11:10]=00 from 8'h1B
        do_walk("R5", va, 0, 0, {20'h00ABC, va[11:0]}, 4'd6, 2'b00, 2, l1a(b, va), ta, 4);
    endtask

    task automatic t_fine_tiny();
        logic [31:0] b = 32'h0012_4000, va = 32'hF00F_F7FF, ta;
        logic [19:0] tb = 20'h4567A;
        ta = {tb, va[19:10], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 3'b000, 4'd3, 3'b000, 2'b11});
        mem_put(ta, {22'h3ABCD, 4'h0, 2'b10, 2'b00, 2'b11});
        do_walk("R8", va, 0, 0, {22'h3ABCD, va[9:0]}, 4'd3, 2'b10, 2, l1a(b, va), ta, 4);
    endtask

    task automatic t_tiny_in_coarse();
        logic [31:0] b = 32'h0012_4000, va = 32'h2223_3000, ta;
        logic [21:0] tb = 22'h00100;
        ta = {tb, va[19:12], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 1'b0, 4'd7, 3'b000, 2'b01});
        mem_put(ta, {22'h3ABCD, 4'h0, 2'b10, 2'b00, 2'b11});
        do_walk("R8", va, 1, 1, 0, 0, 0, 2, l1a(b, va), ta, 4);
    endtask

    task automatic t_l2_fault();
        logic [31:0] b = 32'h0012_4000, va = 32'h7777_7777, ta;
        logic [19:0] tb = 20'h0BEEF;
        ta = {tb, va[19:10], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 3'b000, 4'd15, 3'b000, 2'b11});
        mem_put(ta, 32'hFFFF_FFFC);
        do_walk("R8", va, 1, 1, 0, 0, 0, 2, l1a(b, va), ta, 4);
    endtask

    // New request raised in the cycle done is seen.
    task automatic t_back_to_back();
        logic [31:0] b = 32'h0012_4000, va1 = 32'h3001_1111, va2 = 32'h4002_2222;
        int lat;
        mem_reset();
        mem_put(l1a(b, va1), {12'h111, 8'h00, 2'b01, 1'b0, 4'd1, 3'b000, 2'b10});
        mem_put(l1a(b, va2), {12'h222, 8'h00, 2'b10, 1'b0, 4'd2, 3'b000, 2'b10});
        rd_cnt = 0;
        @(negedge clk); req_valid = 1'b1; req_va = va1;
        @(negedge clk); req_valid = 1'b0;
        wait_done(lat);
        check_res("R9", 0, 0, {12'h111, va1[19:0]}, 4'd1, 2'b01);
        chk("R9", "req_ready in done cycle", req_ready, 1);
        req_valid = 1'b1; req_va = va2;
        @(negedge clk); req_valid = 1'b0;
        chk("R9", "done dropped", done, 0);
        chk("R9", "second request accepted", req_ready, 0);
        wait_done(lat);
        chk("R9", "second latency", lat, 2);
        check_res("R9", 0, 0, {12'h222, va2[19:0]}, 4'd2, 2'b10);
        chk("R9", "second read address", rd_log[1], l1a(b, va2));
        @(negedge clk);
    endtask

    // Base write in the accept cycle: old base used, new base afterwards.
    task automatic t_base_race();
        logic [31:0] ob = 32'h0012_4000, nb = 32'h8000_C000, va = 32'h0010_0000;
        int lat;
        mem_reset();
        rd_cnt = 0;
        @(negedge clk); base_we = 1'b1; base_wdata = nb; req_valid = 1'b1; req_va = va;
        @(negedge clk); base_we = 1'b0; req_valid = 1'b0;
        wait_done(lat);
        chk("R2", "same-cycle base write uses old base", rd_log[0], l1a(ob, va));
        chk("R4", "unmapped fault", fault, 1);
        @(negedge clk);
        do_walk("R2", va, 1, 0, 0, 0, 0, 1, l1a(nb, va), 0, 2);
    endtask

    // Alternating read-ready stall; address must hold until taken.
    task automatic t_stall();
        logic [31:0] b = 32'h8000_C000, va = 32'h9876_5432, ta;
        logic [21:0] tb = 22'h2AAAA;
        ta = {tb, va[19:12], 2'b00};
        mem_reset();
        mem_put(l1a(b, va), {tb, 1'b0, 4'd4, 3'b000, 2'b01});
        mem_put(ta, {16'h1357, 4'h0, 8'hE4, 2'b00, 2'b01});
        stall_en = 1'b1;
        // va[15:14]=1 selects s[7:6]=01
        do_walk("R10", va, 0, 0, {16'h1357, va[15:0]}, 4'd4, 2'b01, 2, l1a(b, va), ta, 0);
        stall_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_section();
        t_l1_fault();
        t_coarse_large();
        t_coarse_small();
        t_fine_small();
        t_fine_tiny();
        t_tiny_in_coarse();
        t_l2_fault();
        t_back_to_back();
        t_base_race();
        t_stall();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule